// File: doc/BRIEF.md
# SDRAM Command and Address Encoder

This block converts one abstract memory request per clock into the pin-level command of a four-bank, 16-bit single-data-rate SDRAM. The pins it drives are chip select, the three strobes RAS, CAS and WE, clock enable, a 13-bit address bus, a 2-bit bank select and two byte masks. Every pin is a flop output that changes only on the rising clock edge.

A request carries an opcode, a bank, a row, a flat 11-bit column index and a single flag. On a read or write the flag asks for auto-precharge. On a precharge it selects all banks. Address bit 10 is reserved for that flag, so the column index is split around it.

A separate mask lane aligns byte masks to data beats. The user presents each mask two cycles before its beat. Read masks go straight out, because the device acts on them two cycles early. Write masks are held back so that they land on the beat itself.

The block also owns clock enable. It enters self refresh and keeps the device there. On exit it raises clock enable behind NOPs and stalls the request handshake for a fixed number of cycles.

Top module: `sdr_cmd_enc`

## Requirements
- R1: During reset: `cs_n_o`=1, `ras_n_o`=`cas_n_o`=`we_n_o`=1, `cke_o`=1, `addr_o`=0, `ba_o`=0, `dqm_o`=0, and `req_ready_o`=1. After reset, every command output reflects the request accepted at the previous rising edge.
- R2: In a cycle with no accepted request, or with opcode 0 (idle), the outputs after the next edge are `cs_n_o`=1, strobes 1,1,1, address 0 and bank 0.
- R3: Command encoding on {ras_n,cas_n,we_n}, with `cs_n_o`=0: activate 0,1,1; read 1,0,1; write 1,0,0; precharge 0,1,0; auto refresh 0,0,1. Opcodes are 1=activate, 2=read, 3=write, 4=precharge, 5=auto refresh, 6=self-refresh entry, 7=self-refresh exit.
- R4: On activate, `addr_o` carries the 13-bit row. On activate, read, write and precharge, `ba_o` carries the request bank. On every other command `ba_o` is 0.
- R5: On read and write, column bits 9..0 drive `addr_o[9:0]`, column bit 10 drives `addr_o[11]`, and `addr_o[12]` is 0.
- R6: On read and write, `addr_o[10]` equals the request flag (auto-precharge).
- R7: On precharge, `addr_o[10]` equals the request flag (1 = all banks) and every other address bit is 0.
- R8: Auto refresh drives address 0 and bank 0, and leaves `cke_o` at 1.
- R9: Self-refresh entry emits the auto-refresh code with `cke_o`=0. While in self refresh, `cke_o` stays 0 and every request other than exit is accepted and produces `cs_n_o`=1.
- R10: Self-refresh exit emits `cs_n_o`=1 with `cke_o`=1. `req_ready_o` then stays low for EXIT_NOPS cycles, during which NOPs are emitted. An exit opcode outside self refresh is a NOP.
- R11: A read mask sampled on an edge appears on `dqm_o` after that edge. A write mask appears MASK_LEAD edges later. Masks that land together are ORed, and with no mask landing `dqm_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_op_i | input | 3 | Opcode (see R3) |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | 13 | Row for activate |
| req_col_i | input | 11 | Flat column index |
| req_flag_i | input | 1 | Auto-precharge / all-bank flag |
| bm_valid_i | input | 1 | Byte mask valid |
| bm_is_rd_i | input | 1 | 1 = read mask, 0 = write mask |
| bm_i | input | 2 | Byte masks {upper, lower} |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| addr_o | output | 13 | Address bus |
| ba_o | output | 2 | Bank select |
| dqm_o | output | 2 | Byte masks {upper, lower} |

## Verification
The bench builds the block with its default parameters: a 13-bit row, an 11-bit column, four banks, a mask lead of 2 and an exit stall of 2. These widths are small enough to sweep all 2048 column indices through the address split. The sweeps also cover every command crossed with every bank and both flag values over edge-pattern rows and columns, and every mask value in both directions. The short exit stall lets the ready-low window and the self-refresh entry, hold and exit sequence be checked cycle by cycle.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_ACT      = 3'd1,
    OP_RD       = 3'd2,
    OP_WR       = 3'd3,
    OP_PRE      = 3'd4,
    OP_REF      = 3'd5,
    OP_SREF_IN  = 3'd6,
    OP_SREF_OUT = 3'd7
  } sdr_op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  typedef enum logic [1:0] {
    PWR_ON   = 2'd0,
    PWR_SELF = 2'd1,
    PWR_EXIT = 2'd2
  } sdr_pwr_e;

  localparam sdr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_ACT   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_RD    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
  localparam sdr_cmd_t CMD_WR    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
  localparam sdr_cmd_t CMD_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdr_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdr_addr_map.sv
module sdr_addr_map
  import sdr_cmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  sdr_op_e             op_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic                flag_i,
  output sdr_cmd_t            cmd_o,
  output logic [ROW_W-1:0]    addr_o,
  output logic [BANK_W-1:0]   ba_o
);

  logic [ROW_W-1:0] col_addr;

  // Column bits at or above AP_BIT shift up one pin to skip the flag pin.
  always_comb begin
    col_addr = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (i < AP_BIT) col_addr[i] = col_i[i];
      else            col_addr[i+1] = col_i[i];
    end
    col_addr[AP_BIT] = flag_i;
  end

  always_comb begin
    cmd_o  = CMD_DESEL;
    addr_o = '0;
    ba_o   = '0;
    unique case (op_i)
      OP_ACT: begin
        cmd_o  = CMD_ACT;
        addr_o = row_i;
        ba_o   = bank_i;
      end
      OP_RD, OP_WR: begin
        cmd_o  = (op_i == OP_RD) ? CMD_RD : CMD_WR;
        addr_o = col_addr;
        ba_o   = bank_i;
      end
      OP_PRE: begin
        cmd_o          = CMD_PRE;
        addr_o[AP_BIT] = flag_i;
        ba_o           = bank_i;
      end
      OP_REF, OP_SREF_IN: cmd_o = CMD_REF;
      default: cmd_o = CMD_DESEL;
    endcase
  end

endmodule

// File: rtl/sdr_pwr_ctl.sv
module sdr_pwr_ctl
  import sdr_cmd_pkg::*;
#(
  parameter int EXIT_NOPS = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    acc_i,
  input  sdr_op_e op_i,
  output logic    ready_o,
  output logic    pwr_on_o,
  output logic    cke_o
);

  localparam int CNT_W = $clog2(EXIT_NOPS) + 1;

  sdr_pwr_e   state_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready_o  = (state_q != PWR_EXIT);
  assign pwr_on_o = (state_q == PWR_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_ON;
      cnt_q   <= '0;
      cke_o   <= 1'b1;
    end else begin
      unique case (state_q)
        PWR_ON: if (acc_i && op_i == OP_SREF_IN) begin
          state_q <= PWR_SELF;
          cke_o   <= 1'b0;
        end
        PWR_SELF: if (acc_i && op_i == OP_SREF_OUT) begin
          state_q <= PWR_EXIT;
          cke_o   <= 1'b1;
          cnt_q   <= CNT_W'(EXIT_NOPS - 1);
        end
        PWR_EXIT: begin
          if (cnt_q == '0) state_q <= PWR_ON;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= PWR_ON;
      endcase
    end
  end

  p_exit_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> !ready_o);

  p_cke_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !(acc_i && op_i == OP_SREF_OUT)) |=> !cke_o);

endmodule

// File: rtl/sdr_mask_align.sv
module sdr_mask_align #(
  parameter int MASK_W    = 2,
  parameter int MASK_LEAD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bm_valid_i,
  input  logic              bm_is_rd_i,
  input  logic [MASK_W-1:0] bm_i,
  output logic [MASK_W-1:0] dqm_o
);

  logic [MASK_W-1:0] wr_pipe [MASK_LEAD];
  logic [MASK_W-1:0] rd_in, wr_in;

  assign rd_in = (bm_valid_i &&  bm_is_rd_i) ? bm_i : '0;
  assign wr_in = (bm_valid_i && !bm_is_rd_i) ? bm_i : '0;

  for (genvar g = 0; g < MASK_LEAD; g++) begin : g_wr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     wr_pipe[g] <= '0;
      else if (g == 0) wr_pipe[g] <= wr_in;
      else             wr_pipe[g] <= wr_pipe[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dqm_o <= '0;
    else         dqm_o <= rd_in | wr_pipe[MASK_LEAD-1];
  end

  p_rd_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_valid_i && bm_is_rd_i) |=> ((dqm_o & $past(bm_i)) == $past(bm_i)));

endmodule

// File: rtl/sdr_cmd_enc.sv
module sdr_cmd_enc
  import sdr_cmd_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 11,
  parameter int BANK_W    = 2,
  parameter int MASK_W    = 2,
  parameter int AP_BIT    = 10,
  parameter int MASK_LEAD = 2,
  parameter int EXIT_NOPS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_flag_i,
  input  logic              bm_valid_i,
  input  logic              bm_is_rd_i,
  input  logic [MASK_W-1:0] bm_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [MASK_W-1:0] dqm_o
);

  sdr_op_e           op_in, eff_op;
  logic              acc, pwr_on;
  sdr_cmd_t          cmd_d;
  logic [ROW_W-1:0]  addr_d;
  logic [BANK_W-1:0] ba_d;

  assign op_in = sdr_op_e'(req_op_i);
  assign acc   = req_valid_i && req_ready_o;

  // Outside normal power state every accepted request becomes a NOP.
  always_comb begin
    eff_op = OP_IDLE;
    if (acc && pwr_on && op_in != OP_SREF_OUT) eff_op = op_in;
  end

  sdr_pwr_ctl #(.EXIT_NOPS(EXIT_NOPS)) u_pwr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .op_i     (op_in),
    .ready_o  (req_ready_o),
    .pwr_on_o (pwr_on),
    .cke_o    (cke_o)
  );

  sdr_addr_map #(
    .ROW_W (ROW_W), .COL_W (COL_W), .BANK_W (BANK_W), .AP_BIT (AP_BIT)
  ) u_map (
    .op_i   (eff_op),
    .bank_i (req_bank_i),
    .row_i  (req_row_i),
    .col_i  (req_col_i),
    .flag_i (req_flag_i),
    .cmd_o  (cmd_d),
    .addr_o (addr_d),
    .ba_o   (ba_d)
  );

  sdr_mask_align #(.MASK_W(MASK_W), .MASK_LEAD(MASK_LEAD)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bm_valid_i (bm_valid_i),
    .bm_is_rd_i (bm_is_rd_i),
    .bm_i       (bm_i),
    .dqm_o      (dqm_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= CMD_DESEL;
      addr_o <= '0;
      ba_o   <= '0;
    end else begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= cmd_d;
      addr_o <= addr_d;
      ba_o   <= ba_d;
    end
  end

  p_desel_nop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (ras_n_o && cas_n_o && we_n_o && addr_o == '0));

  p_sref_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (!cs_n_o && !ras_n_o && !cas_n_o && we_n_o));

  p_low_cke_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> cs_n_o);

  p_act_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && pwr_on && op_in == OP_ACT) |=> (ba_o == $past(req_bank_i) && addr_o == $past(req_row_i)));

endmodule

// File: tb/sdr_cmd_enc_bench.sv
module sdr_cmd_enc_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic        req_flag = 1'b0;
  logic        bm_valid = 1'b0, bm_is_rd = 1'b0;
  logic [1:0]  bm = '0;
  logic        cs_n, ras_n, cas_n, we_n, cke;
  logic [12:0] addr;
  logic [1:0]  ba, dqm;

  int checks = 0;
  int fails  = 0;

  sdr_cmd_enc u_sdr_cmd_enc (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_flag_i(req_flag),
    .bm_valid_i(bm_valid), .bm_is_rd_i(bm_is_rd), .bm_i(bm),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .cke_o(cke),
    .addr_o(addr), .ba_o(ba), .dqm_o(dqm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input int op, input int bank, input int row, input int col, input int flag);
    req_valid = 1'b1;
    req_op    = op[2:0];
    req_bank  = bank[1:0];
    req_row   = row[12:0];
    req_col   = col[10:0];
    req_flag  = flag[0];
  endtask

  function automatic logic [31:0] pins();
    return {12'd0, cke, cs_n, ras_n, cas_n, we_n, addr, ba};
  endfunction

  // Expected {cke,cs,ras,cas,we,addr,ba} for a request in normal power state.
  function automatic logic [31:0] expect_cmd(int op, int bank, int row, int col, int flag);
    logic [3:0] c;
    int a, b;
    c = 4'b1111; a = 0; b = 0;
    case (op)
      1: begin c = 4'b0011; a = row; b = bank; end
      2, 3: begin
        c = (op == 2) ? 4'b0101 : 4'b0100;
        a = (col % 1024) + flag * 1024 + ((col / 1024) % 2) * 2048;
        b = bank;
      end
      4: begin c = 4'b0010; a = flag * 1024; b = bank; end
      5: c = 4'b0001;
      default: c = 4'b1111;
    endcase
    return {12'd0, 1'b1, c, a[12:0], b[1:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  int rows[4] = '{0, 8191, 5461, 2730};
  int cols[5] = '{0, 2047, 1024, 1023, 682};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset pins", pins(), {12'd0, 1'b1, 4'b1111, 13'd0, 2'd0});
    chk("R1 reset dqm", {30'd0, dqm}, 32'd0);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    step();

    // R2 no valid, then idle opcode
    put(1, 3, 100, 0, 1); req_valid = 1'b0;
    step();
    chk("R2 no valid", pins(), expect_cmd(0, 0, 0, 0, 0));
    put(0, 3, 100, 5, 1);
    step();
    chk("R2 idle op", pins(), expect_cmd(0, 0, 0, 0, 0));

    // R3 R4 R5 R6 R7 R8 command sweep
    for (int op = 1; op <= 5; op++)
      for (int b = 0; b < 4; b++)
        for (int f = 0; f < 2; f++)
          for (int r = 0; r < 4; r++)
            for (int c = 0; c < 5; c++) begin
              put(op, b, rows[r], cols[c], f);
              step();
              chk($sformatf("R3/R4/R5/R6/R7/R8 op%0d", op), pins(),
                  expect_cmd(op, b, rows[r], cols[c], f));
            end

    // R5 exhaustive column split
    for (int c = 0; c < 2048; c++) begin
      put(3, c % 4, 0, c, 0);
      step();
      chk("R5 column split", {19'd0, addr}, expect_cmd(3, 0, 0, c, 0) >> 2 & 32'h1fff);
    end

    // R10 exit opcode outside self refresh is a NOP
    put(7, 1, 0, 0, 0);
    step();
    chk("R10 stray exit", pins(), expect_cmd(0, 0, 0, 0, 0));
    chk("R10 stray exit ready", {31'd0, req_ready}, 32'd1);

    // R9 self refresh entry
    put(6, 3, 77, 9, 1);
    step();
    chk("R9 entry", pins(), {12'd0, 1'b0, 4'b0001, 13'd0, 2'd0});
    put(1, 2, 300, 0, 0);
    step();
    chk("R9 ignored act", pins(), {12'd0, 1'b0, 4'b1111, 13'd0, 2'd0});
    chk("R9 ready in self", {31'd0, req_ready}, 32'd1);
    put(6, 0, 0, 0, 0);
    step();
    chk("R9 ignored entry", pins(), {12'd0, 1'b0, 4'b1111, 13'd0, 2'd0});
    put(5, 0, 0, 0, 0);
    step();
    chk("R9 ignored refresh", pins(), {12'd0, 1'b0, 4'b1111, 13'd0, 2'd0});

    // R10 exit and stall
    put(7, 0, 0, 0, 0);
    step();
    chk("R10 exit pins", pins(), {12'd0, 1'b1, 4'b1111, 13'd0, 2'd0});
    chk("R10 stall 1", {31'd0, req_ready}, 32'd0);
    put(1, 1, 4000, 0, 0);
    step();
    chk("R10 nop 1", pins(), expect_cmd(0, 0, 0, 0, 0));
    chk("R10 stall 2", {31'd0, req_ready}, 32'd0);
    step();
    chk("R10 nop 2", pins(), expect_cmd(0, 0, 0, 0, 0));
    chk("R10 ready back", {31'd0, req_ready}, 32'd1);
    step();
    chk("R10 first act", pins(), expect_cmd(1, 1, 4000, 0, 0));
    req_valid = 1'b0;

    // R11 mask alignment
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 4; m++) begin
        bm_valid = 1'b1; bm_is_rd = d[0]; bm = m[1:0];
        step();
        bm_valid = 1'b0; bm = '0;
        chk("R11 edge1", {30'd0, dqm}, (d == 1) ? m : 0);
        step();
        chk("R11 edge2", {30'd0, dqm}, 32'd0);
        step();
        chk("R11 edge3", {30'd0, dqm}, (d == 0) ? m : 0);
        step();
        chk("R11 drain", {30'd0, dqm}, 32'd0);
      end
    // R11 write and read masks landing together
    bm_valid = 1'b1; bm_is_rd = 1'b0; bm = 2'b01;
    step();
    bm_valid = 1'b0;
    step();
    bm_valid = 1'b1; bm_is_rd = 1'b1; bm = 2'b10;
    step();
    bm_valid = 1'b0;
    chk("R11 overlap or", {30'd0, dqm}, 32'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule